// File: doc/BRIEF.md
# Sample Buffer with Threshold Flag

This block sits between a converter core and a host processor. Each converted sample arrives with a one-cycle write strobe and is stored in a 16-word, 10-bit first-in first-out queue. When two channels are converted at the same instant, the core writes channel 1 and then channel 2. The queue keeps that order, so the host reads the pair back as channel 1 followed by channel 2. The host pops one word for each read strobe and sees the fill count at all times.

A data-available output serves as the host's interrupt. It becomes active once the fill count reaches a threshold picked by a 3-bit select. The output can be set to active-high or active-low. It can also be set to follow the fill level or to give a single-cycle pulse each time the threshold is crossed upward. A write that arrives while the queue is full is dropped and sets a sticky overflow flag. Only a global reset or a synchronous queue clear brings that flag low again.

Top module: `sample_queue`

## Requirements
- R1: While the global reset `rstN` is low, and on the first cycle after it is released, the fill count is 0, overflow is 0, read data is 0, and data-available sits at its inactive level.
- R2: Words are read back in the order they were written. The read data and the fill count both change on the clock edge that samples the read strobe, and so does the count after a write.
- R3: The threshold select maps as follows: 0→1, 1→2, 2→4, 3→8, 4→12, 5→14, 6→16, 7→16 words.
- R4: In level mode (`flagPulse`=0), data-available is active in every cycle where the fill count is at least the threshold. It becomes inactive as soon as a read takes the count below the threshold.
- R5: In pulse mode (`flagPulse`=1), data-available is active for exactly one cycle: the first cycle in which the fill count is at or above the threshold after having been below it.
- R6: With `flagActiveLow`=1, the active level of data-available is 0 and the inactive level is 1.
- R7: A write while the count is 16 is discarded. The count stays at 16 and the stored words are unchanged.
- R8: A write while the count is 16 sets overflow on the next edge, even if a read is strobed in the same cycle. Overflow then stays high until a reset or a queue clear.
- R9: A queue clear empties the queue and lowers overflow on the next edge. A write in the same cycle is discarded, and the read data holds its value.
- R10: A read while the queue is empty leaves the read data unchanged and keeps the count at 0.
- R11: A read and a write in the same cycle on a queue that is neither empty nor full leave the count unchanged. Both the pop and the push take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global reset, active low, asynchronous |
| fifoClear | input | 1 | Synchronous queue clear |
| wrEn | input | 1 | Sample write strobe |
| wrData | input | 10 | Sample to store |
| rdEn | input | 1 | Host read strobe |
| trigSel | input | 3 | Threshold select |
| flagActiveLow | input | 1 | 1 selects an active-low data-available output |
| flagPulse | input | 1 | 1 selects pulse mode, 0 selects level mode |
| rdData | output | 10 | Last word popped |
| dataAvail | output | 1 | Threshold flag |
| overflow | output | 1 | Sticky overflow flag |
| fillCount | output | 5 | Number of stored words |

## Verification
The bench targets these corner cases:
- Every threshold, one word below it and exactly at it, in level mode. A decoder that is off by one would raise the flag a word early or a word late.
- Pulse mode through a fall below the threshold and a fresh rise. A design that keeps no memory of the previous level would hold the flag, and one that never re-arms would stay silent.
- A full queue hit with a write alone and with a write plus a read in the same cycle. A design that checks fullness after the pop would accept the extra word, and the last word read back would be wrong.
- Empty reads and a clear that coincides with a write. Here a careless design would wrap its pointers or keep the colliding word.

// File: rtl/sample_queue_pkg.sv
package sample_queue_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } qStrobe_t;

  // Threshold in words for each select code
  function automatic int unsigned trigWords(input logic [2:0] sel);
    case (sel)
      3'd0:    trigWords = 1;
      3'd1:    trigWords = 2;
      3'd2:    trigWords = 4;
      3'd3:    trigWords = 8;
      3'd4:    trigWords = 12;
      3'd5:    trigWords = 14;
      default: trigWords = 16;
    endcase
  endfunction

endpackage

// File: rtl/sample_queue_ctrl.sv
module sample_queue_ctrl
  import sample_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             fifoClear,
  input  logic [2:0]       trigSel,
  input  logic             flagActiveLow,
  input  logic             flagPulse,
  output qStrobe_t         strobe,
  output logic [CNT_W-1:0] fillCount,
  output logic             overflow,
  output logic             dataAvail
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic        isFull;
  logic        isEmpty;
  logic        levelHit;
  logic        prevHit;
  logic        rawFlag;
  int unsigned selWords;
  int unsigned lvlWords;

  assign isFull  = (fillCount == FULL);
  assign isEmpty = (fillCount == '0);

  // Fullness is judged before any pop in the same cycle
  always_comb begin
    strobe.clear = fifoClear;
    strobe.push  = wrEn & ~isFull & ~fifoClear;
    strobe.pop   = rdEn & ~isEmpty & ~fifoClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else if (strobe.clear) begin
      fillCount <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (fifoClear) begin
      overflow <= 1'b0;
    end else if (wrEn && isFull) begin
      overflow <= 1'b1;
    end
  end

  always_comb begin
    selWords = trigWords(trigSel);
    lvlWords = (selWords > DEPTH) ? DEPTH : selWords;
  end

  assign levelHit = (32'(fillCount) >= lvlWords);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevHit <= 1'b0;
    else       prevHit <= levelHit;
  end

  assign rawFlag   = flagPulse ? (levelHit & ~prevHit) : levelHit;
  assign dataAvail = rawFlag ^ flagActiveLow;

endmodule

// File: rtl/sample_queue_store.sv
module sample_queue_store
  import sample_queue_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdPtr];
  end

endmodule

// File: rtl/sample_queue.sv
module sample_queue
  import sample_queue_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoClear,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [2:0]        trigSel,
  input  logic              flagActiveLow,
  input  logic              flagPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              dataAvail,
  output logic              overflow,
  output logic [CNT_W-1:0]  fillCount
);

  qStrobe_t strobe;

  sample_queue_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .fifoClear(fifoClear),
    .trigSel(trigSel), .flagActiveLow(flagActiveLow), .flagPulse(flagPulse),
    .strobe(strobe), .fillCount(fillCount), .overflow(overflow),
    .dataAvail(dataAvail)
  );

  sample_queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/sample_queue_chk.sv
module sample_queue_chk #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoClear,
  input logic              wrEn,
  input logic              rdEn,
  input logic [2:0]        trigSel,
  input logic              flagActiveLow,
  input logic              flagPulse,
  input logic [DATA_W-1:0] rdData,
  input logic              dataAvail,
  input logic              overflow,
  input logic [CNT_W-1:0]  fillCount
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic activeNow;
  assign activeNow = dataAvail ^ flagActiveLow;

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !fifoClear && fillCount == FULL) |=> fillCount == FULL);

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !fifoClear && fillCount == FULL) |=> overflow);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !fifoClear) |=> overflow);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClear |=> (fillCount == '0 && !overflow && $stable(rdData)));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && !fifoClear && fillCount == '0) |=> ($stable(rdData) && fillCount == '0));

  // R11
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn && !fifoClear && fillCount != '0 && fillCount != FULL) |=> $stable(fillCount));

  // R5
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagPulse && activeNow) |=> !(activeNow && $stable(flagPulse) && $stable(trigSel)
                                   && $stable(flagActiveLow)));

endmodule

bind sample_queue sample_queue_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .fifoClear(fifoClear), .wrEn(wrEn), .rdEn(rdEn),
  .trigSel(trigSel), .flagActiveLow(flagActiveLow), .flagPulse(flagPulse),
  .rdData(rdData), .dataAvail(dataAvail), .overflow(overflow), .fillCount(fillCount)
);

// File: tb/sample_queue_test.sv
`timescale 1ns/1ps
module sample_queue_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoClear = 1'b0;
  logic       wrEn = 1'b0;
  logic [9:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [2:0] trigSel = '0;
  logic       flagActiveLow = 1'b0;
  logic       flagPulse = 1'b0;
  logic [9:0] rdData;
  logic       dataAvail;
  logic       overflow;
  logic [4:0] fillCount;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sample_queue uut (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .trigSel(trigSel), .flagActiveLow(flagActiveLow),
    .flagPulse(flagPulse), .rdData(rdData), .dataAvail(dataAvail),
    .overflow(overflow), .fillCount(fillCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply strobes for one edge; returns 5 ns after that edge
  task automatic tick(input bit w, input logic [9:0] d, input bit r, input bit c);
    wrEn = w; wrData = d; rdEn = r; fifoClear = c;
    @(posedge clk);
    #5;
    wrEn = 1'b0; rdEn = 1'b0; fifoClear = 1'b0;
  endtask

  function automatic int levelOf(input int sel);
    case (sel)
      0: return 1; 1: return 2; 2: return 4; 3: return 8;
      4: return 12; 5: return 14; default: return 16;
    endcase
  endfunction

  task automatic testReset();
    check("R1 count", fillCount, 0);
    check("R1 overflow", overflow, 0);
    check("R1 rdData", rdData, 0);
    check("R1 flag", dataAvail, 0);
  endtask

  task automatic testOrder();
    tick(1, 10'h0A1, 0, 0);
    tick(1, 10'h0B2, 0, 0);
    tick(1, 10'h0C3, 0, 0);
    check("R2 count after writes", fillCount, 3);
    tick(0, 0, 1, 0); check("R2 first", rdData, 10'h0A1); check("R2 count", fillCount, 2);
    tick(0, 0, 1, 0); check("R2 second", rdData, 10'h0B2);
    tick(0, 0, 1, 0); check("R2 third", rdData, 10'h0C3);
  endtask

  task automatic testEmptyRead();
    tick(0, 0, 1, 0);
    check("R10 rdData held", rdData, 10'h0C3);
    check("R10 count", fillCount, 0);
    tick(1, 10'h155, 0, 0);
    tick(0, 0, 1, 0);
    check("R10 no wrap", rdData, 10'h155);
  endtask

  task automatic testSimultaneous();
    tick(1, 10'h011, 0, 0);
    tick(1, 10'h022, 1, 0);
    check("R11 count", fillCount, 1);
    check("R11 pop", rdData, 10'h011);
    tick(0, 0, 1, 0);
    check("R11 push kept", rdData, 10'h022);
  endtask

  task automatic testLevels();
    flagPulse = 0; flagActiveLow = 0;
    for (int s = 0; s < 8; s++) begin
      trigSel = 3'(s);
      tick(0, 0, 0, 1);
      for (int i = 0; i < levelOf(s) - 1; i++) tick(1, 10'(i), 0, 0);
      check($sformatf("R3 R4 below sel %0d", s), dataAvail, 0);
      tick(1, 10'h3AA, 0, 0);
      check($sformatf("R3 R4 at sel %0d", s), dataAvail, 1);
      tick(0, 0, 1, 0);
      check($sformatf("R4 drop sel %0d", s), dataAvail, 0);
    end
  endtask

  task automatic testPolarity();
    flagActiveLow = 1; flagPulse = 0; trigSel = 3'd0;
    tick(0, 0, 0, 1);
    check("R6 idle high", dataAvail, 1);
    tick(1, 10'h001, 0, 0);
    check("R6 active low", dataAvail, 0);
    flagActiveLow = 0;
  endtask

  task automatic testPulse();
    flagPulse = 1; trigSel = 3'd2;
    tick(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) tick(1, 10'(i), 0, 0);
    check("R5 before", dataAvail, 0);
    tick(1, 10'h004, 0, 0);
    check("R5 pulse", dataAvail, 1);
    tick(0, 0, 0, 0);
    check("R5 one cycle", dataAvail, 0);
    tick(1, 10'h005, 0, 0);
    check("R5 no repeat", dataAvail, 0);
    tick(0, 0, 1, 0);
    tick(0, 0, 1, 0);
    check("R5 below", dataAvail, 0);
    tick(1, 10'h006, 0, 0);
    check("R5 rearm", dataAvail, 1);
    flagPulse = 0;
  endtask

  task automatic testFull();
    trigSel = 3'd0;
    tick(0, 0, 0, 1);
    for (int i = 0; i < 16; i++) tick(1, 10'(i * 7 + 1), 0, 0);
    check("R7 full count", fillCount, 16);
    check("R8 no overflow yet", overflow, 0);
    tick(1, 10'h3FF, 0, 0);
    check("R7 count held", fillCount, 16);
    check("R8 set", overflow, 1);
    tick(1, 10'h3FE, 1, 0);
    check("R8 read no rescue", fillCount, 15);
    check("R7 head", rdData, 1);
    for (int i = 1; i < 16; i++) tick(0, 0, 1, 0);
    check("R7 last word kept", rdData, 15 * 7 + 1);
    check("R8 sticky", overflow, 1);
  endtask

  task automatic testClear();
    tick(1, 10'h0AB, 0, 0);
    tick(1, 10'h0CD, 0, 1);
    check("R9 count", fillCount, 0);
    check("R9 overflow", overflow, 0);
    check("R9 rdData kept", rdData, 15 * 7 + 1);
    tick(0, 0, 1, 0);
    check("R9 colliding write dropped", rdData, 15 * 7 + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    testReset();
    rstN = 1'b1;
    @(posedge clk); #5;
    testReset();
    testOrder();
    testEmptyRead();
    testSimultaneous();
    testLevels();
    testPolarity();
    testPulse();
    testFull();
    testClear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule